// File: doc/BRIEF.md
# Event Timestamp Capture Unit

This block records the value of a 32-bit free-running cycle counter at the moment a chosen event occurs. The event is either a transition on an external request pin, sampled on a programmable edge after a two-flop synchroniser, or a one-cycle internal once-per-second pulse. Software works through a small register interface. It writes a configuration word, then polls a status word that holds a pending flag, a missed-event flag and a capture sequence count. It reads the captured value as two 16-bit halves, low half first, and writes the pending flag back to zero so that the next event can be taken.

A second event that arrives while a capture is still unread is never silently lost. It always raises the missed-event flag. In overwrite mode it also replaces the stored value and counts as a new capture. Otherwise the first value is kept. Reading the low half takes a snapshot of the high half, so a later overwrite cannot tear a two-word read. Any write to the configuration word clears the sequence count.

Top module: `ets_capture`

## Requirements
- R1: After reset, all four registers read as zero: config (address 0), status (address 1), captured low half (address 2) and captured-high snapshot (address 3).
- R2: With config bit1 (run) set, bit3 (source) clear and bit2 (falling) clear, a rising edge on `ext_req_i` sets status bit0 (pending). The stored value equals `time_i` two clock cycles after the clock edge that first samples the new pin level. Equivalently, if the pin changes mid-cycle while `time_i` holds v, the stored value is v+2.
- R3: With config bit2 set, only falling edges of `ext_req_i` capture. Rising edges are ignored. With bit2 clear, falling edges are ignored.
- R4: With config bit3 set, a cycle in which `pps_i` is high captures the `time_i` value of that same cycle, and `ext_req_i` is ignored.
- R5: While config bit1 (run) is clear, no event changes the status or the stored value.
- R6: Writing status bit0 as 0 clears the pending flag. Writing it as 1 has no effect. Once the flag is cleared, the next event is accepted.
- R7: An event while a capture is pending with config bit0 (overwrite) clear sets status bit1 (missed), keeps the stored value and leaves the sequence count unchanged.
- R8: An event while a capture is pending with config bit0 set sets status bit1, replaces the stored value and increments the sequence count.
- R9: The sequence count in status bits [15:8] increments on every accepted capture and wraps from 255 to 0.
- R10: A write to the config register clears the sequence count. An event in the same cycle as that write is ignored.
- R11: Reading address 2 with `rd_en_i` high snapshots the high half of the stored value. Address 3 returns that snapshot until the next low-half read.
- R12: Writing status bit1 as 0 clears the missed flag. Writing it as 1 leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| time_i | input | 32 | Free-running cycle counter value |
| ext_req_i | input | 1 | Asynchronous external event request pin |
| pps_i | input | 1 | Internal one-cycle once-per-second pulse |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effect on address 2) |
| addr_i | input | 2 | Register address |
| wr_data_i | input | 16 | Register write data |
| rd_data_o | output | 16 | Register read data (combinational from address) |

## Verification
The bound checker watches the capture rules on every cycle. These are that a config write zeroes the count, that an accepted event sets the pending flag and adds one to the count, that an event against a pending capture raises the missed flag and without overwrite leaves the stored value alone, that the snapshot follows a low-half read, and that nothing moves while run is off. Only the directed scenarios can show the exact two-cycle pin latency, the edge polarity selection, source exclusion, the write-one-has-no-effect behaviour of the status flags, wrap of the count after 256 captures and the tear-free two-word read across an overwrite.

// File: rtl/ets_pkg.sv
package ets_pkg;
    localparam logic [1:0] A_CFG   = 2'd0;
    localparam logic [1:0] A_STAT  = 2'd1;
    localparam logic [1:0] A_CAPLO = 2'd2;
    localparam logic [1:0] A_CAPHI = 2'd3;

    localparam int CFG_BITS  = 4;
    localparam int ST_VALID  = 0;
    localparam int ST_MISS   = 1;
    localparam int ST_SEQ_LO = 8;

    // packed MSB..LSB = bit3..bit0 of the config word
    typedef struct packed {
        logic src_int;
        logic falling;
        logic run;
        logic ovw;
    } cfg_t;
endpackage

// File: rtl/ets_edge_sync.sv
module ets_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] sh_d, sh_q;
    logic              last_d, last_q;

    always_comb begin
        sh_d   = {sh_q[STAGES-2:0], pin_i};
        last_d = sh_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            last_q <= 1'b0;
        end else begin
            sh_q   <= sh_d;
            last_q <= last_d;
        end
    end

    assign rise_o = sh_q[STAGES-1] & ~last_q;
    assign fall_o = ~sh_q[STAGES-1] & last_q;
endmodule

// File: rtl/ets_rd_mux.sv
module ets_rd_mux
    import ets_pkg::*;
#(
    parameter int TS_W  = 32,
    parameter int SEQ_W = 8,
    localparam int HALF_W = TS_W / 2
) (
    input  logic [1:0]        addr_i,
    input  cfg_t              cfg_i,
    input  logic              valid_i,
    input  logic              miss_i,
    input  logic [SEQ_W-1:0]  seq_i,
    input  logic [HALF_W-1:0] cap_lo_i,
    input  logic [HALF_W-1:0] hi_snap_i,
    output logic [HALF_W-1:0] data_o
);
    always_comb begin
        data_o = '0;
        case (addr_i)
            A_CFG:   data_o[CFG_BITS-1:0] = cfg_i;
            A_STAT: begin
                data_o[ST_VALID]            = valid_i;
                data_o[ST_MISS]             = miss_i;
                data_o[ST_SEQ_LO +: SEQ_W]  = seq_i;
            end
            A_CAPLO: data_o = cap_lo_i;
            default: data_o = hi_snap_i;
        endcase
    end
endmodule

// File: rtl/ets_capture.sv
module ets_capture
    import ets_pkg::*;
#(
    parameter int TS_W        = 32,
    parameter int SEQ_W       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int HALF_W     = TS_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   time_i,
    input  logic              ext_req_i,
    input  logic              pps_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [1:0]        addr_i,
    input  logic [HALF_W-1:0] wr_data_i,
    output logic [HALF_W-1:0] rd_data_o
);
    typedef struct packed {
        cfg_t              cfg;
        logic              valid;
        logic              miss;
        logic [SEQ_W-1:0]  seq;
        logic [TS_W-1:0]   cap;
        logic [HALF_W-1:0] hi_snap;
    } state_t;

    state_t st_d, st_q;
    logic   ext_rise, ext_fall;
    logic   cfg_wr, stat_wr, lo_rd, trig, evt;
    logic   unused_wdata;

    assign unused_wdata = ^wr_data_i[HALF_W-1:CFG_BITS];

    ets_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_req_i),
        .rise_o (ext_rise),
        .fall_o (ext_fall)
    );

    assign cfg_wr  = wr_en_i && (addr_i == A_CFG);
    assign stat_wr = wr_en_i && (addr_i == A_STAT);
    assign lo_rd   = rd_en_i && (addr_i == A_CAPLO);
    assign trig    = st_q.cfg.src_int ? pps_i
                   : (st_q.cfg.falling ? ext_fall : ext_rise);
    assign evt     = st_q.cfg.run && trig && !cfg_wr;

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d.cfg = cfg_t'(wr_data_i[CFG_BITS-1:0]);
            st_d.seq = '0;
        end
        if (stat_wr) begin
            st_d.valid = st_q.valid & wr_data_i[ST_VALID];
            st_d.miss  = st_q.miss  & wr_data_i[ST_MISS];
        end
        if (lo_rd) begin
            st_d.hi_snap = st_q.cap[TS_W-1:HALF_W];
        end
        if (evt) begin
            if (!st_d.valid) begin
                st_d.cap   = time_i;
                st_d.valid = 1'b1;
                st_d.seq   = st_q.seq + 1'b1;
            end else begin
                st_d.miss = 1'b1;
                if (st_q.cfg.ovw) begin
                    st_d.cap = time_i;
                    st_d.seq = st_q.seq + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    ets_rd_mux #(.TS_W(TS_W), .SEQ_W(SEQ_W)) u_mux (
        .addr_i    (addr_i),
        .cfg_i     (st_q.cfg),
        .valid_i   (st_q.valid),
        .miss_i    (st_q.miss),
        .seq_i     (st_q.seq),
        .cap_lo_i  (st_q.cap[HALF_W-1:0]),
        .hi_snap_i (st_q.hi_snap),
        .data_o    (rd_data_o)
    );
endmodule

// File: rtl/ets_capture_chk.sv
module ets_capture_chk #(
    parameter int TS_W  = 32,
    parameter int SEQ_W = 8,
    localparam int HALF_W = TS_W / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_i,
    input logic              stat_wr_i,
    input logic              lo_rd_i,
    input logic              evt_i,
    input logic              run_i,
    input logic              ovw_i,
    input logic              valid_i,
    input logic              miss_i,
    input logic [SEQ_W-1:0]  seq_i,
    input logic [TS_W-1:0]   cap_i,
    input logic [HALF_W-1:0] hi_snap_i
);
    p_seq_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_i |=> (seq_i == '0));

    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && evt_i) |=> (valid_i && seq_i == SEQ_W'($past(seq_i) + 1'b1)));

    p_miss_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !stat_wr_i && evt_i) |=> miss_i);

    p_keep_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !stat_wr_i && evt_i && !ovw_i) |=> $stable(cap_i));

    p_snapshot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lo_rd_i |=> (hi_snap_i == $past(cap_i[TS_W-1:HALF_W])));

    p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !stat_wr_i) |=> ($stable(valid_i) && $stable(cap_i)));
endmodule

bind ets_capture ets_capture_chk #(.TS_W(TS_W), .SEQ_W(SEQ_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_i  (cfg_wr),
    .stat_wr_i (stat_wr),
    .lo_rd_i   (lo_rd),
    .evt_i     (evt),
    .run_i     (st_q.cfg.run),
    .ovw_i     (st_q.cfg.ovw),
    .valid_i   (st_q.valid),
    .miss_i    (st_q.miss),
    .seq_i     (st_q.seq),
    .cap_i     (st_q.cap),
    .hi_snap_i (st_q.hi_snap)
);

// File: tb/ets_capture_test.sv
module ets_capture_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] tcnt = '0;
    logic [31:0] toff = 32'h1234_FF00;
    logic [31:0] time_i;
    logic        ext_req = 1'b0, pps = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) tcnt <= tcnt + 1;
    assign time_i = tcnt + toff;

    ets_capture uut (
        .clk(clk), .rst_n(rst_n), .time_i(time_i), .ext_req_i(ext_req),
        .pps_i(pps), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
        .wr_data_i(wdata), .rd_data_o(rdata)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0; addr = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0; addr = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [15:0] exp);
        logic [15:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic pin(input logic lvl, output logic [31:0] v);
        @(negedge clk); ext_req = lvl; v = time_i;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse(output logic [31:0] v);
        @(negedge clk); pps = 1'b1; v = time_i;
        @(negedge clk); pps = 1'b0;
    endtask

    function automatic logic [15:0] stat(input int seq, input bit miss, input bit valid);
        return {seq[7:0], 6'b0, miss, valid};
    endfunction

    task automatic t_reset;
        rd_chk("R1 cfg", 2'd0, 16'h0);
        rd_chk("R1 status", 2'd1, 16'h0);
        rd_chk("R1 lo", 2'd2, 16'h0);
        rd_chk("R1 hi", 2'd3, 16'h0);
    endtask

    task automatic t_not_running;
        logic [31:0] v;
        pin(1'b1, v); pin(1'b0, v);
        pulse(v);
        rd_chk("R5 idle status", 2'd1, 16'h0);
        rd_chk("R5 idle lo", 2'd2, 16'h0);
    endtask

    task automatic t_rising;
        logic [31:0] v, e;
        wr(2'd0, 16'h0002);
        pin(1'b1, v); e = v + 2;
        rd_chk("R2 status", 2'd1, stat(1, 0, 1));
        rd_chk("R2 lo", 2'd2, e[15:0]);
        rd_chk("R2 hi", 2'd3, e[31:16]);
        wr(2'd1, 16'h0000);
        rd_chk("R6 cleared", 2'd1, stat(1, 0, 0));
        pin(1'b0, v);
        rd_chk("R3 falling ignored", 2'd1, stat(1, 0, 0));
        wr(2'd1, 16'h0003);
        rd_chk("R6 write one no effect", 2'd1, stat(1, 0, 0));
        pin(1'b1, v); e = v + 2;
        rd_chk("R6 reaccept", 2'd1, stat(2, 0, 1));
        rd_chk("R6 reaccept lo", 2'd2, e[15:0]);
        wr(2'd1, 16'h0000);
    endtask

    task automatic t_falling_and_miss;
        logic [31:0] v, e;
        wr(2'd0, 16'h0006);
        rd_chk("R10 seq cleared", 2'd1, stat(0, 0, 0));
        pin(1'b0, v); e = v + 2;
        rd_chk("R3 falling status", 2'd1, stat(1, 0, 1));
        rd_chk("R3 falling lo", 2'd2, e[15:0]);
        pin(1'b1, v);
        rd_chk("R3 rising ignored", 2'd1, stat(1, 0, 1));
        pin(1'b0, v);
        rd_chk("R7 miss status", 2'd1, stat(1, 1, 1));
        rd_chk("R7 value kept", 2'd2, e[15:0]);
        wr(2'd1, 16'h0001);
        rd_chk("R12 miss cleared", 2'd1, stat(1, 0, 1));
    endtask

    task automatic t_overwrite_and_internal;
        logic [31:0] v;
        wr(2'd0, 16'h000B);
        pulse(v);
        rd_chk("R8 overwrite status", 2'd1, stat(1, 1, 1));
        rd_chk("R8 overwrite lo", 2'd2, v[15:0]);
        wr(2'd1, 16'h0002);
        rd_chk("R12 write one keeps miss", 2'd1, stat(1, 1, 0));
        wr(2'd1, 16'h0000);
        pin(1'b1, v); pin(1'b0, v);
        rd_chk("R4 pin ignored", 2'd1, stat(1, 0, 0));
        pulse(v);
        rd_chk("R4 pulse status", 2'd1, stat(2, 0, 1));
        rd_chk("R4 pulse lo", 2'd2, v[15:0]);
    endtask

    task automatic t_snapshot;
        logic [31:0] v1, v2;
        logic [15:0] d;
        pulse(v1);
        rd(2'd2, d);
        chk("R11 lo first", d, v1[15:0]);
        toff = toff + 32'h0001_0000;
        pulse(v2);
        rd_chk("R11 hi from snapshot", 2'd3, v1[31:16]);
        rd_chk("R11 new lo", 2'd2, v2[15:0]);
        rd_chk("R11 new hi", 2'd3, v2[31:16]);
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        wr(2'd0, 16'h000B);
        for (int i = 0; i < 255; i++) pulse(v);
        rd_chk("R9 count 255", 2'd1, stat(255, 1, 1));
        pulse(v); pulse(v);
        rd_chk("R9 wrapped", 2'd1, stat(1, 1, 1));
    endtask

    task automatic t_cfg_collision;
        logic [15:0] lo;
        rd(2'd2, lo);
        @(negedge clk); wr_en = 1'b1; addr = 2'd0; wdata = 16'h000B; pps = 1'b1;
        @(negedge clk); wr_en = 1'b0; addr = '0; pps = 1'b0;
        rd_chk("R10 collision seq", 2'd1, stat(0, 1, 1));
        rd_chk("R10 collision lo", 2'd2, lo);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_not_running;
        t_rising;
        t_falling_and_miss;
        t_overwrite_and_internal;
        t_snapshot;
        t_wrap;
        t_cfg_collision;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule